// File: doc/BRIEF.md
# Command Mailbox with Busy Semaphore

This block is the single command slot between a host core and a communication engine. The host writes one byte. The upper nibble is an opcode and the lower nibble is a channel number. If the slot is free, the write takes the slot and raises a busy flag. The block then looks up the channel's class and checks whether that class supports the opcode. A supported command goes to the engine as a one-clock strobe, together with the opcode, the channel and the decoded class. An unsupported pair produces no strobe. Instead it frees the slot one cycle later and records an illegal-command status bit.

The engine frees the slot by pulsing `done`. A command write that arrives while the slot is busy is dropped and sets a sticky overrun bit. Both status bits are cleared by writing ones to a second write address. The host can read the flag, both status bits and the held command at any time.

Top module: `cmbx_mailbox`

## Requirements
- R1: After reset, `rd_data` is zero, `cmd_valid` is low and the busy flag reads 0.
- R2: A command write (`wr_addr`=0) while the flag is 0 is accepted. From the next cycle the flag reads 1, and `rd_data[7:4]`/`rd_data[3:0]` hold `wr_data[7:4]` (opcode) and `wr_data[3:0]` (channel).
- R3: For a legal pair, `cmd_valid` is high for exactly the one cycle after the accepting write. During that cycle `cmd_op`/`cmd_chan` carry the command.
- R4: Channel classes and legal opcodes:
  - Channels 0–3 are class full (`cmd_class`=1) and accept opcodes 0–8.
  - Channels 4–7 are class lite (2) and accept 0, 1, 2, 3, 4, 6 and 7.
  - Channels 8–9 are class dma (3) and accept 0, 4 and 9.
  - Channels 10–15 are class none (0) and accept nothing.
  - `cmd_class` reports the class of the held command.
- R5: An illegal pair raises no strobe. The flag reads 1 for one cycle, then 0, and the illegal bit `rd_data[9]` is set at that same edge.
- R6: `done` clears the flag only while the flag is 1. A `done` pulse while the flag is 0 changes nothing.
- R7: A command write while the flag is 1 leaves the held command and the flag unchanged, raises no strobe, and sets the sticky overrun bit `rd_data[8]`.
- R8: A write to `wr_addr`=1 clears the illegal bit where `wr_data[1]`=1 and the overrun bit where `wr_data[0]`=1. A set in the same cycle wins over a clear.
- R9: `rd_data` is {flag, illegal, overrun, opcode, channel}, with the flag at bit 10 and the channel in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | 0 = command slot, 1 = status clear |
| wr_data | input | 8 | Opcode/channel, or clear mask in bits 1:0 |
| rd_data | output | 11 | {flag, illegal, overrun, opcode, channel} |
| done | input | 1 | Engine completion pulse |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_op | output | 4 | Held opcode |
| cmd_chan | output | 4 | Held channel |
| cmd_class | output | 2 | Class of the held channel (0 none, 1 full, 2 lite, 3 dma) |

## Verification
Every one of the 256 opcode/channel pairs is written into an idle slot, followed by a `done` pulse. This sweep separates legal from illegal decode at every class boundary. Because `done` also lands in idle cycles after illegal pairs, the sweep shows that `done` is ignored when the slot is free. Further patterns are applied on their own:
- a second write while busy, which separates overrun from overwrite;
- `done` in the same cycle as the strobe;
- a status clear in the same cycle as an illegal set, which shows set priority;
- a new write in the very cycle the slot frees.

// File: rtl/cmbx_pkg.sv
package cmbx_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_FULL = 2'd1,
    CLS_LITE = 2'd2,
    CLS_DMA  = 2'd3
  } chan_class_e;
endpackage

// File: rtl/cmbx_decode.sv
module cmbx_decode
  import cmbx_pkg::*;
#(
  parameter int OP_W         = 4,
  parameter int CH_W         = 4,
  parameter int FULL_CH      = 4,
  parameter int LITE_CH      = 4,
  parameter int DMA_CH       = 2,
  parameter int FULL_LAST_OP = 8,
  parameter int GRACE_OP     = 5,
  parameter int GROUP_OP     = 8,
  parameter int DMA_INIT_OP  = 0,
  parameter int DMA_STOP_OP  = 4,
  parameter int DMA_ARM_OP   = 9
) (
  input  logic [OP_W-1:0] op,
  input  logic [CH_W-1:0] chan,
  output chan_class_e     cls,
  output logic            legal
);
  localparam int NCH = 2 ** CH_W;
  localparam int NOP = 2 ** OP_W;
  localparam logic [NOP-1:0] ONE       = {{(NOP-1){1'b0}}, 1'b1};
  localparam logic [NOP-1:0] FULL_MASK = (ONE << (FULL_LAST_OP + 1)) - ONE;
  localparam logic [NOP-1:0] LITE_MASK = FULL_MASK & ~(ONE << GRACE_OP) & ~(ONE << GROUP_OP);
  localparam logic [NOP-1:0] DMA_MASK  = (ONE << DMA_INIT_OP) | (ONE << DMA_STOP_OP)
                                       | (ONE << DMA_ARM_OP);
  localparam int LITE_BASE = FULL_CH;
  localparam int DMA_BASE  = FULL_CH + LITE_CH;
  localparam int NONE_BASE = FULL_CH + LITE_CH + DMA_CH;

  chan_class_e    cls_tab  [NCH];
  logic [NOP-1:0] mask_tab [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    if (i < LITE_BASE) begin : g_full
      assign cls_tab[i]  = CLS_FULL;
      assign mask_tab[i] = FULL_MASK;
    end else if (i < DMA_BASE) begin : g_lite
      assign cls_tab[i]  = CLS_LITE;
      assign mask_tab[i] = LITE_MASK;
    end else if (i < NONE_BASE) begin : g_dma
      assign cls_tab[i]  = CLS_DMA;
      assign mask_tab[i] = DMA_MASK;
    end else begin : g_none
      assign cls_tab[i]  = CLS_NONE;
      assign mask_tab[i] = '0;
    end
  end

  always_comb begin
    cls   = cls_tab[chan];
    legal = mask_tab[chan][op];
  end
endmodule

// File: rtl/cmbx_sema.sv
module cmbx_sema
  import cmbx_pkg::*;
#(
  parameter int OP_W = 4,
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic            done,
  input  logic            legal,
  input  chan_class_e     in_cls,
  input  logic [OP_W-1:0] in_op,
  input  logic [CH_W-1:0] in_ch,
  output logic            flag,
  output logic            strobe,
  output logic            bad_pend,
  output logic            busy_hit,
  output logic [OP_W-1:0] op_q,
  output logic [CH_W-1:0] ch_q,
  output chan_class_e     cls_q
);
  logic        flag_q, flag_d;
  logic        strb_q, strb_d;
  logic        bad_q,  bad_d;
  logic        accept;
  logic        ld_en;
  logic [OP_W-1:0] op_d;
  logic [CH_W-1:0] ch_d;
  chan_class_e     cls_d;

  always_comb begin
    accept   = cmd_wr & ~flag_q;
    busy_hit = cmd_wr &  flag_q;
    ld_en    = accept;
    strb_d   = accept & legal;
    bad_d    = accept & ~legal;

    flag_d = flag_q;
    if (accept)               flag_d = 1'b1;
    else if (bad_q)           flag_d = 1'b0;
    else if (flag_q && done)  flag_d = 1'b0;

    op_d  = ld_en ? in_op  : op_q;
    ch_d  = ld_en ? in_ch  : ch_q;
    cls_d = ld_en ? in_cls : cls_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      strb_q <= 1'b0;
      bad_q  <= 1'b0;
      op_q   <= '0;
      ch_q   <= '0;
      cls_q  <= CLS_NONE;
    end else begin
      flag_q <= flag_d;
      strb_q <= strb_d;
      bad_q  <= bad_d;
      op_q   <= op_d;
      ch_q   <= ch_d;
      cls_q  <= cls_d;
    end
  end

  assign flag     = flag_q;
  assign strobe   = strb_q;
  assign bad_pend = bad_q;
endmodule

// File: rtl/cmbx_status.sv
module cmbx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_ill,
  input  logic       set_ovr,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  output logic       ill,
  output logic       ovr
);
  logic ill_q, ill_d, ovr_q, ovr_d;

  always_comb begin
    ill_d = set_ill | (ill_q & ~(clr_wr & clr_bits[1]));
    ovr_d = set_ovr | (ovr_q & ~(clr_wr & clr_bits[0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ill_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ill_q <= ill_d;
      ovr_q <= ovr_d;
    end
  end

  assign ill = ill_q;
  assign ovr = ovr_q;
endmodule

// File: rtl/cmbx_mailbox.sv
module cmbx_mailbox
  import cmbx_pkg::*;
#(
  parameter int OP_W    = 4,
  parameter int CH_W    = 4,
  parameter int FULL_CH = 4,
  parameter int LITE_CH = 4,
  parameter int DMA_CH  = 2,
  localparam int WD_W   = OP_W + CH_W,
  localparam int RD_W   = WD_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [WD_W-1:0] wr_data,
  output logic [RD_W-1:0] rd_data,
  input  logic            done,
  output logic            cmd_valid,
  output logic [OP_W-1:0] cmd_op,
  output logic [CH_W-1:0] cmd_chan,
  output logic [1:0]      cmd_class
);
  logic            cmd_wr, clr_wr;
  logic [OP_W-1:0] in_op;
  logic [CH_W-1:0] in_ch;
  chan_class_e     in_cls, cls_q;
  logic            legal;
  logic            flag, bad_pend, busy_hit, ill, ovr;
  logic [OP_W-1:0] op_q;
  logic [CH_W-1:0] ch_q;

  always_comb begin
    cmd_wr = wr_en & ~wr_addr;
    clr_wr = wr_en &  wr_addr;
    in_op  = wr_data[WD_W-1:CH_W];
    in_ch  = wr_data[CH_W-1:0];
  end

  cmbx_decode #(
    .OP_W(OP_W), .CH_W(CH_W),
    .FULL_CH(FULL_CH), .LITE_CH(LITE_CH), .DMA_CH(DMA_CH)
  ) u_dec (
    .op(in_op), .chan(in_ch), .cls(in_cls), .legal(legal)
  );

  cmbx_sema #(.OP_W(OP_W), .CH_W(CH_W)) u_sema (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .done(done),
    .legal(legal), .in_cls(in_cls), .in_op(in_op), .in_ch(in_ch),
    .flag(flag), .strobe(cmd_valid), .bad_pend(bad_pend),
    .busy_hit(busy_hit), .op_q(op_q), .ch_q(ch_q), .cls_q(cls_q)
  );

  cmbx_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_ill(bad_pend), .set_ovr(busy_hit),
    .clr_wr(clr_wr), .clr_bits(wr_data[1:0]), .ill(ill), .ovr(ovr)
  );

  always_comb begin
    rd_data   = {flag, ill, ovr, op_q, ch_q};
    cmd_op    = op_q;
    cmd_chan  = ch_q;
    cmd_class = cls_q;
  end
endmodule

// File: rtl/cmbx_checker.sv
module cmbx_checker #(
  parameter int RD_W = 11,
  parameter int WD_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_addr,
  input logic [RD_W-1:0] rd_data,
  input logic            cmd_valid,
  input logic [1:0]      cmd_class
);
  logic flag, ill, cmd_wr;
  assign flag   = rd_data[RD_W-1];
  assign ill    = rd_data[RD_W-2];
  assign cmd_wr = wr_en & ~wr_addr;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R3
  AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> flag && $past(cmd_wr && !flag)); // R3
  AST_STROBE_HAS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_class != 2'd0); // R4
  AST_ILLEGAL_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ill) |-> !flag && !cmd_valid); // R5
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !cmd_wr) |=> !flag); // R6
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && flag) |=> rd_data[RD_W-3] && $stable(rd_data[WD_W-1:0]) && !cmd_valid); // R7
endmodule

bind cmbx_mailbox cmbx_checker #(.RD_W(RD_W), .WD_W(WD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_class(cmd_class)
);

// File: tb/cmbx_mailbox_test.sv
module cmbx_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        done = 1'b0;
  logic [10:0] rd_data;
  logic        cmd_valid;
  logic [3:0]  cmd_op, cmd_chan;
  logic [1:0]  cmd_class;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cmbx_mailbox uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .done(done),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_chan(cmd_chan),
    .cmd_class(cmd_class)
  );

  // Reference model of the requirements
  function automatic int ref_class(int ch);
    if (ch < 4) return 1;
    if (ch < 8) return 2;
    if (ch < 10) return 3;
    return 0;
  endfunction

  function automatic bit ref_legal(int op, int ch);
    case (ref_class(ch))
      1: return op <= 8;
      2: return op inside {0, 1, 2, 3, 4, 6, 7};
      3: return op inside {0, 4, 9};
      default: return 1'b0;
    endcase
  endfunction

  bit m_flag, m_ill, m_ovr, m_valid, m_bad;
  int m_op, m_ch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_ill = 0; m_ovr = 0; m_valid = 0; m_bad = 0;
      m_op = 0; m_ch = 0;
    end else begin
      bit old_flag, old_bad;
      old_flag = m_flag;
      old_bad  = m_bad;
      m_valid  = 0;
      m_bad    = 0;
      if (wr_en && wr_addr) begin
        if (wr_data[1]) m_ill = 0;
        if (wr_data[0]) m_ovr = 0;
      end
      if (old_bad) begin
        m_flag = 0;
        m_ill  = 1;
      end else if (old_flag && done) begin
        m_flag = 0;
      end
      if (wr_en && !wr_addr) begin
        if (old_flag) m_ovr = 1;
        else begin
          m_flag = 1;
          m_op   = int'(wr_data[7:4]);
          m_ch   = int'(wr_data[3:0]);
          if (ref_legal(m_op, m_ch)) m_valid = 1;
          else m_bad = 1;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 R5 R6 flag bit 10", int'(rd_data[10]), int'(m_flag));
      check("R5 R8 illegal bit 9", int'(rd_data[9]), int'(m_ill));
      check("R7 R8 overrun bit 8", int'(rd_data[8]), int'(m_ovr));
      check("R2 R7 R9 held opcode", int'(rd_data[7:4]), m_op);
      check("R2 R7 R9 held channel", int'(rd_data[3:0]), m_ch);
      check("R3 R5 cmd_valid", int'(cmd_valid), int'(m_valid));
      if (m_valid) begin
        check("R3 cmd_op", int'(cmd_op), m_op);
        check("R3 cmd_chan", int'(cmd_chan), m_ch);
        check("R4 cmd_class", int'(cmd_class), ref_class(m_ch));
      end
    end
  end

  task automatic drive(bit w, bit a, logic [7:0] d, bit dn);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; done = dn;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 8'h00, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rd_data after reset", int'(rd_data), 0);
    check("R1 cmd_valid after reset", int'(cmd_valid), 0);

    // R4 R5 R6: full sweep, done pulse also lands on idle slots
    for (int c = 0; c < 16; c++) begin
      for (int o = 0; o < 16; o++) begin
        drive(1, 0, 8'((o << 4) | c), 0);
        idle(1);
        drive(0, 0, 8'h00, 1);
        idle(1);
      end
      drive(1, 1, 8'h03, 0);
      idle(1);
    end

    // R7: write while busy
    drive(1, 0, 8'h21, 0);
    drive(1, 0, 8'h72, 0);
    idle(2);
    drive(0, 0, 8'h00, 1);
    idle(1);

    // R6 R3: done in the strobe cycle
    drive(1, 0, 8'h05, 0);
    drive(0, 0, 8'h00, 1);
    idle(2);

    // R8: set beats clear in the same cycle
    drive(1, 0, 8'h0C, 0);
    drive(1, 1, 8'h03, 0);
    idle(2);
    drive(1, 1, 8'h02, 0);
    idle(1);

    // R2: new write in the cycle the slot frees
    drive(1, 0, 8'h48, 0);
    drive(0, 0, 8'h00, 1);
    drive(1, 0, 8'h93, 0);
    idle(1);
    drive(0, 0, 8'h00, 1);
    idle(2);

    // R7 R8: overrun clear only
    drive(1, 0, 8'h10, 0);
    drive(1, 0, 8'h11, 0);
    drive(1, 1, 8'h01, 1);
    idle(2);

    summary();
    $finish;
  end
endmodule